// File: doc/BRIEF.md
# Sector buffer transfer engine

This block empties a 16 KiB sector buffer. Software first loads a 16-bit buffer address counter, a 16-bit byte counter and a destination address, and then issues a trigger. The trigger is honoured only while data output is enabled. A 3-bit destination code sampled at that moment picks the mode.

In host mode a processor pulls one 16-bit word per read strobe. The engine walks the address counter up and the byte counter down until the count, taken as a signed value, is no longer positive. In streaming mode the engine sends (count + 1) / 2 words to a destination port over a valid/ready handshake. It can send one word per cycle. When the stream is finished it moves the address counter and the destination address forward in one step.

Both modes end the same way. The byte counter is reloaded and the active-low status flags return high, except the end-of-transfer flag, which goes low. An interrupt pulse is raised when both enables allow it.

Top module: `sector_xfer`

## Requirements
- R1: After synchronous reset, `busy_n`, `rd_open_n` and `end_flag_n` are 1. `irq`, `data_ready`, `eot`, `dma_valid` and `host_dv` are 0. `addr_cnt`, `byte_cnt` and `dest_addr` are 0.
- R2: A `trig` pulse while `out_en` is 0 changes no output.
- R3: A `trig` with `out_en`=1 drives `busy_n` to 0, clears bits 15:12 of `byte_cnt`, and clears `eot` and `data_ready`. Destination code 2 or 3 also drives `rd_open_n` to 0 and sets `data_ready`.
- R4: A host read returns the buffer word at word address `addr_cnt[13:1]`, so bit 0 is ignored and the address wraps at 16 KiB. Each buffer word carries the even byte in bits 15:8. `host_dv` and `host_data` appear two clock edges after the strobe edge.
- R5: Each accepted host read adds 2 to `addr_cnt` and subtracts 2 from `byte_cnt`.
- R6: A transfer ends when the decremented byte count is zero or negative as a signed 16-bit value, or when a stream ends. At the end, `byte_cnt` becomes 0xF000, `busy_n` and `rd_open_n` become 1, `end_flag_n` becomes 0, `data_ready` becomes 0 and `eot` becomes 1.
- R7: `irq` pulses for one cycle at transfer end, only when `end_irq_en` and `lvl_en` are both 1.
- R8: A host read while `rd_open_n` is 1 returns 0xFFFF and leaves every counter and flag unchanged.
- R9: Codes 4 and 5 start a stream, and so does code 7 when `bank_grant` is 1. The stream carries (`byte_cnt[11:0]` + 1) >> 1 words, read in order from `addr_cnt[13:1]` upward with wrap at 16 KiB. With `dma_ready` held at 1 it sends one word per cycle.
- R10: While `dma_valid` is 1 and `dma_ready` is 0, `dma_valid` stays 1 and `dma_data` holds its value.
- R11: The end of a stream takes effect on the clock edge after the edge that accepted the last word, or one edge after the trigger when the word count is 0. At that point `addr_cnt` advances by twice the word count. `dest_addr` advances by words >> 1 for code 4 and by words >> 2 for codes 5 and 7.
- R12: A trigger with code 0, 1 or 6, or with code 7 while `bank_grant` is 0, drives `busy_n` low and starts neither mode.
- R13: A trigger while a stream is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Load pulse for the three counters |
| ld_addr | input | 16 | Value loaded into the buffer address counter |
| ld_bytes | input | 16 | Value loaded into the byte counter |
| ld_dest | input | 16 | Value loaded into the destination address |
| out_en | input | 1 | Data output enable, gates triggers |
| end_irq_en | input | 1 | Transfer-end interrupt enable |
| lvl_en | input | 1 | External interrupt level enable |
| bank_grant | input | 1 | Shared destination granted to this engine (code 7) |
| dst_code | input | 3 | Destination code sampled at trigger |
| trig | input | 1 | Transfer trigger pulse |
| host_rd | input | 1 | Host word read strobe |
| host_data | output | 16 | Host read data |
| host_dv | output | 1 | Host read data valid |
| buf_re | output | 1 | Buffer read enable |
| buf_addr | output | 13 | Buffer word address |
| buf_rdata | input | 16 | Buffer read data, one cycle after `buf_re` |
| dma_valid | output | 1 | Stream word valid |
| dma_ready | input | 1 | Stream word accepted |
| dma_data | output | 16 | Stream word |
| addr_cnt | output | 16 | Buffer address counter |
| byte_cnt | output | 16 | Byte counter |
| dest_addr | output | 16 | Destination address |
| busy_n | output | 1 | Transfer busy, active low |
| rd_open_n | output | 1 | Host data available, active low |
| end_flag_n | output | 1 | Transfer-end interrupt flag, active low |
| irq | output | 1 | One-cycle interrupt request |
| data_ready | output | 1 | Host data ready |
| eot | output | 1 | End of transfer |

## Verification
Host reads are tried from an odd start address just below the top of the buffer, which shows whether bit 0 is dropped and whether the address wraps. They are also tried with byte counts of 1 and 6, which show whether the signed end test fires on a negative count as well as on zero. Streams are run with `dma_ready` held high and with a stalling pattern. Comparing every accepted word against a behavioural model separates lost or repeated words from simple throttling. Streams of 0, 5, 8 and 16 words under codes 4, 5 and 7 tell the two destination step sizes apart. Codes 0, 1, 6 and ungranted code 7, a trigger with output disabled, and a trigger issued mid-stream check that each is ignored in its own way.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam logic [2:0] DST_HOST_A = 3'd2;
  localparam logic [2:0] DST_HOST_B = 3'd3;
  localparam logic [2:0] DST_WAVE   = 3'd4;
  localparam logic [2:0] DST_PROG   = 3'd5;
  localparam logic [2:0] DST_SHARED = 3'd7;

  typedef enum logic [1:0] {
    M_NONE,
    M_HOST,
    M_STREAM
  } xfer_mode_e;
endpackage

// File: rtl/sx_dma_seq.sv
module sx_dma_seq #(
  parameter int AW    = 13,
  parameter int WRD_W = 12,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    start_ptr,
  input  logic [WRD_W-1:0] start_words,
  output logic             buf_re,
  output logic [AW-1:0]    buf_addr,
  input  logic [DW-1:0]    buf_rdata,
  output logic             dma_valid,
  input  logic             dma_ready,
  output logic [DW-1:0]    dma_data,
  output logic             busy,
  output logic             done
);
  logic [WRD_W-1:0] left;
  logic [AW-1:0]    ptr;
  logic             run, infl;
  logic [1:0]       cnt;
  logic [DW-1:0]    q0, q1;
  logic             pop, push, issue;
  logic [1:0]       occ;

  assign pop  = (cnt != 2'd0) && dma_ready;
  assign push = infl;
  // slots committed once this cycle's pop is taken into account
  assign occ   = cnt + {1'b0, infl} - {1'b0, pop};
  assign issue = run && (left != '0) && (occ < 2'd2);
  assign done  = run && (left == '0) && !infl && (cnt == 2'd0);

  assign buf_re    = issue;
  assign buf_addr  = ptr;
  assign busy      = run;
  assign dma_valid = (cnt != 2'd0);
  assign dma_data  = q0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      left <= '0;
      ptr  <= '0;
      infl <= 1'b0;
      cnt  <= 2'd0;
      q0   <= '0;
      q1   <= '0;
    end else begin
      infl <= issue;
      if (start) begin
        run  <= 1'b1;
        left <= start_words;
        ptr  <= start_ptr;
      end else begin
        if (issue) begin
          left <= left - 1'b1;
          ptr  <= ptr + 1'b1;
        end
        if (done) run <= 1'b0;
      end
      case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) q0 <= buf_rdata;
          else             q1 <= buf_rdata;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          q0  <= q1;
          cnt <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) q0 <= buf_rdata;
          else begin
            q0 <= q1;
            q1 <= buf_rdata;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sx_ctrl.sv
module sx_ctrl
  import sx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BUF_AW   = 14,
  parameter int CLR_BITS = 4,
  parameter int DW       = 16,
  parameter logic [CNT_W-1:0] END_RELOAD = 16'hF000,
  localparam int WRD_W = CNT_W - CLR_BITS,
  localparam int AW    = BUF_AW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_addr,
  input  logic [CNT_W-1:0] ld_bytes,
  input  logic [CNT_W-1:0] ld_dest,
  input  logic             out_en,
  input  logic             end_irq_en,
  input  logic             lvl_en,
  input  logic             bank_grant,
  input  logic [2:0]       dst_code,
  input  logic             trig,
  input  logic             host_rd,
  input  logic [DW-1:0]    buf_rdata,
  input  logic             dma_busy,
  input  logic             dma_done,
  output logic             dma_start,
  output logic [AW-1:0]    dma_ptr,
  output logic [WRD_W-1:0] dma_words,
  output logic             host_re,
  output logic [AW-1:0]    host_addr,
  output logic [DW-1:0]    host_data,
  output logic             host_dv,
  output logic [CNT_W-1:0] addr_cnt,
  output logic [CNT_W-1:0] byte_cnt,
  output logic [CNT_W-1:0] dest_addr,
  output logic             busy_n,
  output logic             rd_open_n,
  output logic             end_flag_n,
  output logic             irq,
  output logic             data_ready,
  output logic             eot
);
  logic             trig_ok, host_go, host_last, fin;
  logic [CNT_W-1:0] cnt_clr, cnt_dec;
  logic [WRD_W:0]   wsum;
  logic [WRD_W-1:0] xfer_words;
  logic             xfer_wave;
  logic             rd_pend, rd_ok;
  xfer_mode_e       mode;

  always_comb begin
    case (dst_code)
      DST_HOST_A, DST_HOST_B: mode = M_HOST;
      DST_WAVE, DST_PROG:     mode = M_STREAM;
      DST_SHARED:             mode = bank_grant ? M_STREAM : M_NONE;
      default:                mode = M_NONE;
    endcase
  end

  assign trig_ok   = trig && out_en && !dma_busy;
  assign cnt_clr   = {{CLR_BITS{1'b0}}, byte_cnt[WRD_W-1:0]};
  assign wsum      = {1'b0, cnt_clr[WRD_W-1:0]} + 1'b1;
  assign dma_words = wsum[WRD_W:1];
  assign dma_start = trig_ok && (mode == M_STREAM);
  assign dma_ptr   = addr_cnt[BUF_AW-1:1];

  assign host_go   = host_rd && !rd_open_n;
  assign host_re   = host_go;
  assign host_addr = addr_cnt[BUF_AW-1:1];
  assign cnt_dec   = byte_cnt - 2;
  assign host_last = cnt_dec[CNT_W-1] || (cnt_dec == '0);
  assign fin       = (host_go && host_last) || dma_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_cnt   <= '0;
      byte_cnt   <= '0;
      dest_addr  <= '0;
      busy_n     <= 1'b1;
      rd_open_n  <= 1'b1;
      end_flag_n <= 1'b1;
      irq        <= 1'b0;
      data_ready <= 1'b0;
      eot        <= 1'b0;
      xfer_words <= '0;
      xfer_wave  <= 1'b0;
      rd_pend    <= 1'b0;
      rd_ok      <= 1'b0;
      host_dv    <= 1'b0;
      host_data  <= '1;
    end else begin
      irq     <= 1'b0;
      rd_pend <= host_rd;
      rd_ok   <= host_go;
      host_dv <= rd_pend;
      host_data <= rd_ok ? buf_rdata : {DW{1'b1}};
      if (ld) begin
        addr_cnt  <= ld_addr;
        byte_cnt  <= ld_bytes;
        dest_addr <= ld_dest;
      end
      if (trig_ok) begin
        busy_n     <= 1'b0;
        byte_cnt   <= cnt_clr;
        eot        <= 1'b0;
        data_ready <= 1'b0;
        if (mode == M_HOST) begin
          rd_open_n  <= 1'b0;
          data_ready <= 1'b1;
        end
        if (dma_start) begin
          xfer_words <= dma_words;
          xfer_wave  <= (dst_code == DST_WAVE);
        end
      end
      if (host_go) begin
        addr_cnt <= addr_cnt + 2;
        byte_cnt <= cnt_dec;
      end
      if (dma_done) begin
        addr_cnt  <= addr_cnt + {{(CNT_W-WRD_W-1){1'b0}}, xfer_words, 1'b0};
        dest_addr <= dest_addr + {{(CNT_W-WRD_W){1'b0}},
                                  (xfer_wave ? (xfer_words >> 1) : (xfer_words >> 2))};
      end
      if (fin) begin
        byte_cnt   <= END_RELOAD;
        busy_n     <= 1'b1;
        rd_open_n  <= 1'b1;
        end_flag_n <= 1'b0;
        irq        <= end_irq_en && lvl_en;
        data_ready <= 1'b0;
        eot        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sector_xfer.sv
module sector_xfer #(
  parameter int CNT_W    = 16,
  parameter int BUF_AW   = 14,
  parameter int CLR_BITS = 4,
  parameter int DW       = 16,
  localparam int WRD_W = CNT_W - CLR_BITS,
  localparam int AW    = BUF_AW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_addr,
  input  logic [CNT_W-1:0] ld_bytes,
  input  logic [CNT_W-1:0] ld_dest,
  input  logic             out_en,
  input  logic             end_irq_en,
  input  logic             lvl_en,
  input  logic             bank_grant,
  input  logic [2:0]       dst_code,
  input  logic             trig,
  input  logic             host_rd,
  output logic [DW-1:0]    host_data,
  output logic             host_dv,
  output logic             buf_re,
  output logic [AW-1:0]    buf_addr,
  input  logic [DW-1:0]    buf_rdata,
  output logic             dma_valid,
  input  logic             dma_ready,
  output logic [DW-1:0]    dma_data,
  output logic [CNT_W-1:0] addr_cnt,
  output logic [CNT_W-1:0] byte_cnt,
  output logic [CNT_W-1:0] dest_addr,
  output logic             busy_n,
  output logic             rd_open_n,
  output logic             end_flag_n,
  output logic             irq,
  output logic             data_ready,
  output logic             eot
);
  logic             dma_start, dma_busy, dma_done, dma_re, host_re;
  logic [AW-1:0]    dma_ptr, dma_addr, host_addr;
  logic [WRD_W-1:0] dma_words;

  sx_ctrl #(.CNT_W(CNT_W), .BUF_AW(BUF_AW), .CLR_BITS(CLR_BITS), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .ld(ld), .ld_addr(ld_addr), .ld_bytes(ld_bytes),
    .ld_dest(ld_dest), .out_en(out_en), .end_irq_en(end_irq_en), .lvl_en(lvl_en),
    .bank_grant(bank_grant), .dst_code(dst_code), .trig(trig), .host_rd(host_rd),
    .buf_rdata(buf_rdata), .dma_busy(dma_busy), .dma_done(dma_done),
    .dma_start(dma_start), .dma_ptr(dma_ptr), .dma_words(dma_words),
    .host_re(host_re), .host_addr(host_addr), .host_data(host_data),
    .host_dv(host_dv), .addr_cnt(addr_cnt), .byte_cnt(byte_cnt),
    .dest_addr(dest_addr), .busy_n(busy_n), .rd_open_n(rd_open_n),
    .end_flag_n(end_flag_n), .irq(irq), .data_ready(data_ready), .eot(eot)
  );

  sx_dma_seq #(.AW(AW), .WRD_W(WRD_W), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .start(dma_start), .start_ptr(dma_ptr),
    .start_words(dma_words), .buf_re(dma_re), .buf_addr(dma_addr),
    .buf_rdata(buf_rdata), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_data(dma_data), .busy(dma_busy), .done(dma_done)
  );

  // host reads and streaming never overlap: host mode leaves the streamer idle
  assign buf_re   = host_re | dma_re;
  assign buf_addr = dma_busy ? dma_addr : host_addr;
endmodule

// File: rtl/sx_checker.sv
module sx_checker #(
  parameter int CNT_W = 16,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ld,
  input logic             trig,
  input logic             host_rd,
  input logic             end_irq_en,
  input logic             lvl_en,
  input logic             dma_valid,
  input logic             dma_ready,
  input logic [DW-1:0]    dma_data,
  input logic [CNT_W-1:0] addr_cnt,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             busy_n,
  input logic             rd_open_n,
  input logic             end_flag_n,
  input logic             irq,
  input logic             data_ready,
  input logic             eot
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_data));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !end_flag_n && $past(end_irq_en && lvl_en));

  // R8
  closed_read_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd && rd_open_n && busy_n && !ld && !trig |=> $stable(addr_cnt) && $stable(byte_cnt));

  // R6
  end_state_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eot) |-> busy_n && rd_open_n && !end_flag_n && !data_ready && byte_cnt == 16'hF000);

  // R3
  host_open_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_open_n) |-> data_ready && !busy_n);

  // R9
  stream_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dma_valid |-> rd_open_n && !busy_n);
endmodule

bind sector_xfer sx_checker #(.CNT_W(CNT_W), .DW(DW)) u_sx_checker (
  .clk(clk), .rst(rst), .ld(ld), .trig(trig), .host_rd(host_rd),
  .end_irq_en(end_irq_en), .lvl_en(lvl_en), .dma_valid(dma_valid),
  .dma_ready(dma_ready), .dma_data(dma_data), .addr_cnt(addr_cnt),
  .byte_cnt(byte_cnt), .busy_n(busy_n), .rd_open_n(rd_open_n),
  .end_flag_n(end_flag_n), .irq(irq), .data_ready(data_ready), .eot(eot)
);

// File: tb/test_sector_xfer.sv
`timescale 1ns/1ps
module test_sector_xfer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, ld, out_en, end_irq_en, lvl_en, bank_grant, trig, host_rd, dma_ready;
  logic [15:0] ld_addr, ld_bytes, ld_dest;
  logic [2:0]  dst_code;
  logic [15:0] host_data, dma_data, addr_cnt, byte_cnt, dest_addr, buf_rdata;
  logic        host_dv, buf_re, dma_valid, busy_n, rd_open_n, end_flag_n, irq, data_ready, eot;
  logic [12:0] buf_addr;

  sector_xfer i_sector_xfer (
    .clk(clk), .rst(rst), .ld(ld), .ld_addr(ld_addr), .ld_bytes(ld_bytes),
    .ld_dest(ld_dest), .out_en(out_en), .end_irq_en(end_irq_en), .lvl_en(lvl_en),
    .bank_grant(bank_grant), .dst_code(dst_code), .trig(trig), .host_rd(host_rd),
    .host_data(host_data), .host_dv(host_dv), .buf_re(buf_re), .buf_addr(buf_addr),
    .buf_rdata(buf_rdata), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_data(dma_data), .addr_cnt(addr_cnt), .byte_cnt(byte_cnt),
    .dest_addr(dest_addr), .busy_n(busy_n), .rd_open_n(rd_open_n),
    .end_flag_n(end_flag_n), .irq(irq), .data_ready(data_ready), .eot(eot)
  );

  int checks = 0, fails = 0;
  string phase = "R1";
  bit stall_mode = 0;
  bit finished = 0;

  function automatic logic [15:0] pat(input logic [12:0] a);
    logic [15:0] x;
    x = {3'b000, a};
    return x * 16'h9E37 + 16'h1234;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // buffer with one-cycle read latency
  always_ff @(posedge clk) if (buf_re) buf_rdata <= pat(buf_addr);

  // behavioural reference model
  logic [15:0] m_addr, m_bytes, m_dest;
  bit m_busy_n, m_open_n, m_flag_n, m_irq, m_ready, m_eot, m_dma, m_wave;
  int m_left, m_words;
  logic [12:0] m_ptr;
  logic [15:0] hq[$];

  task automatic m_finish();
    m_bytes  = 16'hF000;
    m_busy_n = 1; m_open_n = 1; m_flag_n = 0;
    m_irq    = end_irq_en && lvl_en;
    m_ready  = 0; m_eot = 1;
  endtask

  always @(posedge clk) begin
    bit was_dma;
    logic [15:0] t;
    if (rst) begin
      m_addr = 0; m_bytes = 0; m_dest = 0;
      m_busy_n = 1; m_open_n = 1; m_flag_n = 1; m_irq = 0; m_ready = 0; m_eot = 0;
      m_dma = 0; m_left = 0; m_words = 0; m_ptr = 0; m_wave = 0;
      hq.delete();
    end else begin
      was_dma = m_dma;
      m_irq = 0;
      if (m_dma) begin
        if (m_left == 0) begin
          m_addr = m_addr + 16'(2 * m_words);
          m_dest = m_dest + 16'(m_wave ? (m_words >> 1) : (m_words >> 2));
          m_finish();
          m_dma = 0;
        end else if (dma_valid && dma_ready) begin
          chk(phase, "stream word", dma_data, pat(m_ptr));
          m_ptr = m_ptr + 13'd1;
          m_left--;
        end
      end else if (dma_valid) chk(phase, "unexpected dma_valid", 1, 0);
      if (ld) begin m_addr = ld_addr; m_bytes = ld_bytes; m_dest = ld_dest; end
      if (trig && out_en && !was_dma) begin
        m_busy_n = 0; m_bytes = m_bytes & 16'h0FFF; m_eot = 0; m_ready = 0;
        if (dst_code == 3'd2 || dst_code == 3'd3) begin m_open_n = 0; m_ready = 1; end
        else if (dst_code == 3'd4 || dst_code == 3'd5 || (dst_code == 3'd7 && bank_grant)) begin
          m_dma = 1; m_words = (int'(m_bytes) + 1) >> 1; m_left = m_words;
          m_ptr = m_addr[13:1]; m_wave = (dst_code == 3'd4);
        end
      end
      if (host_rd) begin
        if (!m_open_n) begin
          hq.push_back(pat(m_addr[13:1]));
          m_addr = m_addr + 16'd2;
          t = m_bytes - 16'd2;
          m_bytes = t;
          if ($signed(t) <= 0) m_finish();
        end else hq.push_back(16'hFFFF);
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(phase, "addr_cnt", addr_cnt, m_addr);
      chk(phase, "byte_cnt", byte_cnt, m_bytes);
      chk(phase, "dest_addr", dest_addr, m_dest);
      chk(phase, "busy_n", busy_n, m_busy_n);
      chk(phase, "rd_open_n", rd_open_n, m_open_n);
      chk(phase, "end_flag_n", end_flag_n, m_flag_n);
      chk(phase, "irq", irq, m_irq);
      chk(phase, "data_ready", data_ready, m_ready);
      chk(phase, "eot", eot, m_eot);
      if (host_dv) begin
        if (hq.size() == 0) chk(phase, "host_dv without read", 1, 0);
        else chk(phase, "host_data", host_data, hq.pop_front());
      end
    end
  end

  // ready pattern driver
  initial begin
    int n = 0;
    dma_ready = 1;
    forever begin
      @(negedge clk);
      n++;
      dma_ready = stall_mode ? ((n % 3) != 0 && (n % 7) != 2) : 1'b1;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b, input logic [15:0] d);
    @(negedge clk); ld = 1; ld_addr = a; ld_bytes = b; ld_dest = d;
    @(negedge clk); ld = 0;
  endtask

  task automatic fire(input logic [2:0] code);
    @(negedge clk); trig = 1; dst_code = code;
    @(negedge clk); trig = 0;
  endtask

  task automatic hread();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic wait_eot();
    int k = 0;
    while (!eot && k < 400) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1; ld = 0; out_en = 0; end_irq_en = 0; lvl_en = 0; bank_grant = 0;
    trig = 0; host_rd = 0; dst_code = 0; ld_addr = 0; ld_bytes = 0; ld_dest = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R1";
    chk("R1", "busy_n", busy_n, 1); chk("R1", "rd_open_n", rd_open_n, 1);
    chk("R1", "end_flag_n", end_flag_n, 1); chk("R1", "eot", eot, 0);
    chk("R1", "byte_cnt", byte_cnt, 0); chk("R1", "dma_valid", dma_valid, 0);

    phase = "R2";
    load(16'h0100, 16'h0006, 16'h0000);
    fire(3'd2);
    repeat (2) @(negedge clk);
    chk("R2", "busy_n after disabled trigger", busy_n, 1);
    chk("R2", "byte_cnt after disabled trigger", byte_cnt, 16'h0006);

    phase = "R3";
    out_en = 1; end_irq_en = 1; lvl_en = 1;
    load(16'h0100, 16'hF006, 16'h0000);
    fire(3'd2);
    chk("R3", "byte_cnt top bits cleared", byte_cnt, 16'h0006);
    chk("R3", "data_ready", data_ready, 1);
    phase = "R5";
    hread(); hread();
    chk("R5", "addr_cnt after two reads", addr_cnt, 16'h0104);
    phase = "R6";
    hread();
    chk("R6", "eot", eot, 1); chk("R6", "byte_cnt reload", byte_cnt, 16'hF000);
    chk("R7", "irq pulse", irq, 1);
    @(negedge clk);
    chk("R7", "irq one cycle", irq, 0);
    phase = "R8";
    hread(); repeat (3) @(negedge clk);
    chk("R8", "addr_cnt after closed read", addr_cnt, 16'h0106);

    phase = "R4";
    do_reset();
    lvl_en = 0;
    load(16'h3FFD, 16'h0006, 16'h0000);
    fire(3'd3);
    hread(); hread(); hread();
    repeat (3) @(negedge clk);
    chk("R4", "addr_cnt wrapped source", addr_cnt, 16'h4003);
    chk("R7", "irq blocked by level enable", irq, 0);
    chk("R4", "all host words returned", hq.size(), 0);

    phase = "R6";
    do_reset();
    lvl_en = 1;
    load(16'h0010, 16'h0001, 16'h0000);
    fire(3'd2);
    hread(); repeat (2) @(negedge clk);
    chk("R6", "negative count ends", eot, 1);

    phase = "R9";
    do_reset();
    load(16'h3FF8, 16'h0009, 16'h0010);
    fire(3'd5);
    wait_eot();
    chk("R11", "addr_cnt after 5 words", addr_cnt, 16'h4002);
    chk("R11", "dest step code 5", dest_addr, 16'h0011);

    phase = "R10";
    do_reset();
    stall_mode = 1;
    load(16'h0200, 16'h0010, 16'h0020);
    fire(3'd4);
    wait_eot();
    stall_mode = 0;
    chk("R11", "dest step code 4", dest_addr, 16'h0024);

    phase = "R13";
    do_reset();
    bank_grant = 1;
    load(16'h1000, 16'h001F, 16'h0100);
    fire(3'd7);
    fire(3'd2);
    chk("R13", "trigger mid-stream ignored", rd_open_n, 1);
    wait_eot();
    chk("R11", "dest step code 7", dest_addr, 16'h0104);
    chk("R11", "addr_cnt after 16 words", addr_cnt, 16'h1020);

    phase = "R12";
    do_reset();
    bank_grant = 0;
    load(16'h0000, 16'h0010, 16'h0000);
    fire(3'd7);
    repeat (5) @(negedge clk);
    chk("R12", "busy_n low ungranted", busy_n, 0);
    chk("R12", "no stream ungranted", dma_valid, 0);
    do_reset();
    load(16'h0000, 16'h0010, 16'h0000);
    fire(3'd6);
    repeat (5) @(negedge clk);
    chk("R12", "code 6 no host", rd_open_n, 1);
    chk("R12", "code 6 no end", eot, 0);

    phase = "R11";
    do_reset();
    load(16'h0040, 16'h0000, 16'h0008);
    fire(3'd5);
    @(negedge clk);
    chk("R11", "zero-word stream ends", eot, 1);
    chk("R11", "zero-word addr", addr_cnt, 16'h0040);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule